// File: doc/BRIEF.md
# External Memory High-Address Pin Controller

This block holds the 8-bit configuration register of a microcontroller's external memory bus, together with the pin logic that register drives. The bus has an 8-bit port that carries address and data on the same lines, and a separate 8-bit port for the high address byte. A 3-bit mask code in the register decides how many of the upper high-address pins carry address bits. The pins it does not claim go back to ordinary port control.

A keeper enable bit holds the last driven level on the address/data lines while nobody drives them. This bit acts on its own: it works whether or not the memory interface is enabled. The block also decodes the CPU data-space address to tell whether an access belongs to internal memory or goes out on the external bus. The internal region is larger in normal mode than in compatibility mode.

The bus timing sequencer and the wait-state logic sit outside this block. They use the block's access strobe and keeper outputs.

Top module: `xmem_hipin_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the keeper is disabled, and its held value is 0x00.
- R2: A register write stores bit 7 and bits 2:0 of the write data. Bits 6:3 always read back as zero, whatever was written to them. The read data shows the register contents in the same cycle.
- R3: The keeper enable output is high exactly when register bit 7 is one and the bus drive enable is low. This holds regardless of the external-memory enable.
- R4: The keeper value output holds the pad value sampled at the last rising clock edge at which the bus drive enable was high. It does not change while the bus is not driven.
- R5: Mask code c in bits 2:0 selects how many high-address bits are used. Code 0 uses 8 bits, code c from 1 to 6 uses 8−c bits, and code 7 uses none. High pin i (0..7) carries address only when external memory is enabled and i is below that count.
- R6: A high pin that carries address is an output (oe=1) and drives CPU address bit 8+i.
- R7: A released high pin copies the port's output value and direction inputs. While external memory is disabled, all eight pins are released, whatever the mask code.
- R8: In normal mode (compat_mode=0) the external access strobe is high only for addresses at or above 0x1100.
- R9: In compatibility mode (compat_mode=1) the external access strobe is high only for addresses at or above 0x1000.
- R10: The external access strobe is low whenever external memory is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| xmem_en | input | 1 | External memory interface enable |
| compat_mode | input | 1 | Selects the smaller internal region |
| cpu_addr | input | 16 | CPU data-space address |
| bus_drive_en | input | 1 | Address/data lines are being driven |
| ad_pad_in | input | 8 | Level seen on the address/data pads |
| port_out | input | 8 | Port output values for the high pins |
| port_dir | input | 8 | Port direction values for the high pins (1 = output) |
| hi_pin_out | output | 8 | High-address pin output value |
| hi_pin_oe | output | 8 | High-address pin output enable |
| keep_val | output | 8 | Level the keeper holds on the address/data lines |
| keep_en | output | 1 | Keeper is holding the address/data lines |
| ext_access | output | 1 | Current address goes to external memory |

## Verification
The hardest case to reach is the keeper holding a value after the drive enable has dropped. This must also hold while the memory interface is off, and across a change of the mask code. To get there, the stimulus first drives distinct pad patterns under bus drive. It then releases the bus with xmem_en low and the keeper bit set. After that it rewrites the mask and the reserved bits, and checks that the held value stays put. Directed cycles sweep all eight mask codes with the interface both on and off. Other cycles put addresses on each side of both region limits, and a long random run follows.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int CFG_W    = 8;
  localparam int KEEP_BIT = 7;
  localparam int MASK_W   = 3;

  // Number of high-address pins still carrying address for a mask code.
  function automatic logic [3:0] hi_bits_used(input logic [MASK_W-1:0] code);
    if (code == {MASK_W{1'b1}}) return 4'd0;
    return 4'd8 - {1'b0, code};
  endfunction

  // Lowest external address for the current mode.
  function automatic logic [15:0] region_limit(input logic compat,
                                               input logic [15:0] norm_lim,
                                               input logic [15:0] comp_lim);
    return compat ? comp_lim : norm_lim;
  endfunction
endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             keep_on,
  output logic [MASK_W-1:0] mask_code
);
  logic             keep_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
      mask_q <= '0;
    end else if (we) begin
      keep_q <= wdata[KEEP_BIT];
      mask_q <= wdata[MASK_W-1:0];
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[KEEP_BIT]      = keep_q;
    rdata[MASK_W-1:0]    = mask_q;
  end

  assign keep_on   = keep_q;
  assign mask_code = mask_q;
endmodule

// File: rtl/xmem_keeper.sv
module xmem_keeper #(
  parameter int AD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            keep_on,
  input  logic            drive_en,
  input  logic [AD_W-1:0] pad_in,
  output logic [AD_W-1:0] held,
  output logic            hold_en
);
  logic [AD_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (drive_en) held_q <= pad_in;
  end

  assign held    = held_q;
  assign hold_en = keep_on & ~drive_en;
endmodule

// File: rtl/xmem_hi_port_mux.sv
module xmem_hi_port_mux
  import xmem_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic              xmem_en,
  input  logic [MASK_W-1:0] mask_code,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [HI_W-1:0]   port_out,
  input  logic [HI_W-1:0]   port_dir,
  output logic [HI_W-1:0]   pin_out,
  output logic [HI_W-1:0]   pin_oe,
  output logic [HI_W-1:0]   pin_is_addr
);
  logic [3:0] used;
  assign used = hi_bits_used(mask_code);

  for (genvar i = 0; i < HI_W; i++) begin : g_pin
    assign pin_is_addr[i] = xmem_en && (4'(i) < used);
    assign pin_out[i]     = pin_is_addr[i] ? addr_hi[i] : port_out[i];
    assign pin_oe[i]      = pin_is_addr[i] ? 1'b1       : port_dir[i];
  end
endmodule

// File: rtl/xmem_region_decode.sv
module xmem_region_decode
  import xmem_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] NORM_LIM  = 16'h1100,
  parameter logic [15:0] COMP_LIM  = 16'h1000
) (
  input  logic              xmem_en,
  input  logic              compat,
  input  logic [ADDR_W-1:0] addr,
  output logic              ext_hit
);
  logic [15:0] limit;
  assign limit   = region_limit(compat, NORM_LIM, COMP_LIM);
  assign ext_hit = xmem_en && (addr >= ADDR_W'(limit));
endmodule

// File: rtl/xmem_hipin_ctrl.sv
module xmem_hipin_ctrl
  import xmem_pkg::*;
#(
  parameter int          AD_W     = 8,
  parameter int          HI_W     = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] NORM_LIM = 16'h1100,
  parameter logic [15:0] COMP_LIM = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              xmem_en,
  input  logic              compat_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              bus_drive_en,
  input  logic [AD_W-1:0]   ad_pad_in,
  input  logic [HI_W-1:0]   port_out,
  input  logic [HI_W-1:0]   port_dir,
  output logic [HI_W-1:0]   hi_pin_out,
  output logic [HI_W-1:0]   hi_pin_oe,
  output logic [AD_W-1:0]   keep_val,
  output logic              keep_en
  ,output logic             ext_access
);
  localparam int HI_LSB = ADDR_W - HI_W;

  logic              keep_on;
  logic [MASK_W-1:0] mask_code;
  logic [HI_W-1:0]   pin_is_addr;

  xmem_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .keep_on(keep_on), .mask_code(mask_code)
  );

  xmem_keeper #(.AD_W(AD_W)) u_keep (
    .clk(clk), .rst_n(rst_n), .keep_on(keep_on), .drive_en(bus_drive_en),
    .pad_in(ad_pad_in), .held(keep_val), .hold_en(keep_en)
  );

  xmem_hi_port_mux #(.HI_W(HI_W)) u_mux (
    .xmem_en(xmem_en), .mask_code(mask_code),
    .addr_hi(cpu_addr[HI_LSB +: HI_W]), .port_out(port_out),
    .port_dir(port_dir), .pin_out(hi_pin_out), .pin_oe(hi_pin_oe),
    .pin_is_addr(pin_is_addr)
  );

  xmem_region_decode #(.ADDR_W(ADDR_W), .NORM_LIM(NORM_LIM), .COMP_LIM(COMP_LIM)) u_dec (
    .xmem_en(xmem_en), .compat(compat_mode), .addr(cpu_addr), .ext_hit(ext_access)
  );
endmodule

// File: rtl/xmem_hipin_chk.sv
module xmem_hipin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_rdata,
  input logic        xmem_en,
  input logic        compat_mode,
  input logic [15:0] cpu_addr,
  input logic        bus_drive_en,
  input logic [7:0]  port_out,
  input logic [7:0]  port_dir,
  input logic [7:0]  hi_pin_out,
  input logic [7:0]  hi_pin_oe,
  input logic [7:0]  keep_val,
  input logic        keep_en,
  input logic        ext_access
);
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:3] == 4'b0000);

  assert_keep_off_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> !keep_en);

  assert_keep_follows_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_en |-> (keep_en == cfg_rdata[7]));

  assert_keep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_en |=> $stable(keep_val));

  assert_all_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xmem_en |-> (hi_pin_oe == port_dir && hi_pin_out == port_out));

  assert_code7_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xmem_en && cfg_rdata[2:0] == 3'd7) |-> (hi_pin_oe == port_dir));

  assert_code0_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xmem_en && cfg_rdata[2:0] == 3'd0) |-> (hi_pin_oe == 8'hFF && hi_pin_out == cpu_addr[15:8]));

  assert_ext_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xmem_en |-> !ext_access);

  assert_low_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h1000) |-> !ext_access);

  assert_gap_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xmem_en && cpu_addr >= 16'h1000 && cpu_addr < 16'h1100) |-> (ext_access == compat_mode));
endmodule

bind xmem_hipin_ctrl xmem_hipin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .xmem_en(xmem_en),
  .compat_mode(compat_mode), .cpu_addr(cpu_addr), .bus_drive_en(bus_drive_en),
  .port_out(port_out), .port_dir(port_dir), .hi_pin_out(hi_pin_out),
  .hi_pin_oe(hi_pin_oe), .keep_val(keep_val), .keep_en(keep_en),
  .ext_access(ext_access)
);

// File: tb/tb_xmem_hipin_ctrl.sv
module tb_xmem_hipin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        xmem_en = 1'b0;
  logic        compat_mode = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        bus_drive_en = 1'b0;
  logic [7:0]  ad_pad_in = '0;
  logic [7:0]  port_out = '0;
  logic [7:0]  port_dir = '0;
  logic [7:0]  hi_pin_out, hi_pin_oe, keep_val;
  logic        keep_en, ext_access;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_keep_bit = 0;
  int m_mask = 0;
  int m_held = 0;

  always #2 clk = ~clk;

  xmem_hipin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xmem_en(xmem_en), .compat_mode(compat_mode),
    .cpu_addr(cpu_addr), .bus_drive_en(bus_drive_en), .ad_pad_in(ad_pad_in),
    .port_out(port_out), .port_dir(port_dir), .hi_pin_out(hi_pin_out),
    .hi_pin_oe(hi_pin_oe), .keep_val(keep_val), .keep_en(keep_en),
    .ext_access(ext_access)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare all outputs against the behavioural model.
  task automatic compare_all();
    int used, e_oe, e_out, lim, e_ext;
    chk("R2 rdata", int'(cfg_rdata), m_keep_bit * 128 + m_mask);
    chk("R3 keep_en", int'(keep_en), (m_keep_bit == 1 && !bus_drive_en) ? 1 : 0);
    chk("R4 keep_val", int'(keep_val), m_held);
    used = (m_mask == 7) ? 0 : 8 - m_mask;
    e_oe = 0; e_out = 0;
    for (int i = 0; i < 8; i++) begin
      if (xmem_en && i < used) begin
        e_oe  += (1 << i);
        e_out += int'(cpu_addr[8+i]) << i;
      end else begin
        e_oe  += int'(port_dir[i]) << i;
        e_out += int'(port_out[i]) << i;
      end
    end
    if (xmem_en) begin
      chk("R5 R6 hi_pin_oe", int'(hi_pin_oe), e_oe);
      chk("R5 R6 hi_pin_out", int'(hi_pin_out), e_out);
    end else begin
      chk("R7 hi_pin_oe", int'(hi_pin_oe), e_oe);
      chk("R7 hi_pin_out", int'(hi_pin_out), e_out);
    end
    lim = compat_mode ? 4096 : 4352;
    e_ext = (xmem_en && int'(cpu_addr) >= lim) ? 1 : 0;
    if (!xmem_en)        chk("R10 ext_access", int'(ext_access), e_ext);
    else if (compat_mode) chk("R9 ext_access", int'(ext_access), e_ext);
    else                  chk("R8 ext_access", int'(ext_access), e_ext);
  endtask

  // One cycle: inputs set after a falling edge, checked, then model advanced.
  task automatic step(input bit we, input logic [7:0] wd, input bit xe, input bit cm,
                      input logic [15:0] a, input bit de, input logic [7:0] pad,
                      input logic [7:0] po, input logic [7:0] pd);
    cfg_we = we; cfg_wdata = wd; xmem_en = xe; compat_mode = cm;
    cpu_addr = a; bus_drive_en = de; ad_pad_in = pad; port_out = po; port_dir = pd;
    #1;
    compare_all();
    @(posedge clk);
    if (we) begin
      m_keep_bit = int'(wd[7]);
      m_mask = int'(wd[2:0]);
    end
    if (de) m_held = int'(pad);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", int'(cfg_rdata), 0);
    chk("R1 keep_en", int'(keep_en), 0);
    chk("R1 keep_val", int'(keep_val), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 8'h00, 1, 0, 16'hA5C3, 0, 8'h00, 8'h0F, 8'hF0);

    // R2: reserved bits ignored
    step(1, 8'hFF, 0, 0, 16'h0000, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 0, 0, 16'h0000, 0, 8'h00, 8'h00, 8'h00);
    step(1, 8'h78, 0, 0, 16'h0000, 0, 8'h00, 8'h00, 8'h00);

    // R5 R6 R7: sweep every mask code with interface on and off
    for (int c = 0; c < 8; c++) begin
      step(1, 8'(c), 1, 0, 16'h5A00, 0, 8'h00, 8'h33, 8'h0C);
      step(0, 8'h00, 1, 0, 16'hC3FF, 0, 8'h00, 8'h33, 8'h0C);
      step(0, 8'h00, 0, 0, 16'hC3FF, 0, 8'h00, 8'h96, 8'h69);
    end

    // R8 R9 R10: region boundaries
    step(1, 8'h00, 1, 0, 16'h10FF, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 1, 0, 16'h1100, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 1, 1, 16'h0FFF, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 1, 1, 16'h1000, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 1, 1, 16'h10FF, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 0, 1, 16'hFFFF, 0, 8'h00, 8'h00, 8'h00);
    step(0, 8'h00, 0, 0, 16'hFFFF, 0, 8'h00, 8'h00, 8'h00);

    // R3 R4: keeper with memory interface disabled, across config rewrites
    step(1, 8'h80, 0, 0, 16'h0000, 1, 8'hA5, 8'h00, 8'h00);
    step(0, 8'h00, 0, 0, 16'h0000, 1, 8'h3C, 8'h00, 8'h00);
    step(0, 8'h00, 0, 0, 16'h0000, 0, 8'hFF, 8'h00, 8'h00);
    step(1, 8'hFB, 0, 0, 16'h0000, 0, 8'h11, 8'h00, 8'h00);
    step(1, 8'h06, 1, 0, 16'h2000, 0, 8'h22, 8'h00, 8'h00);
    step(0, 8'h00, 1, 0, 16'h2000, 0, 8'h44, 8'h00, 8'h00);

    // random run
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (n % 4 == 0) a = 16'h0FF0 + 16'($urandom_range(0, 32'h120));
      step(($urandom_range(0, 5) == 0), 8'($urandom), 1'($urandom), 1'($urandom),
           a, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule